// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds eight binary semaphores that two independent agents, a left port and a right port, use to agree on the use of shared resources. Neither port can stall the other. Each port picks a semaphore through the low bits of its address. It requests a token by writing 0 and gives the token back by writing 1. It then reads back whether it holds the token.

Each semaphore keeps one active-low request latch per side and one ownership record. A request on a free semaphore is granted at once. A request made while the other side holds the token waits in its latch. That waiting request is granted as soon as the owner releases the token. A read takes a snapshot of the addressed flag when the read begins and holds that value for as long as the read stays active.

Top module: `sem_bank`

## Requirements
- R1: After reset all request latches are clear, every semaphore is free, and both ports read 1 from every index.
- R2: The semaphore index is the three lowest address bits. The higher address bits have no effect. An access to one index leaves the other seven indices unchanged.
- R3: A write (select and write strobe high) samples only data bit 0. A 0 sets that side's request and a 1 clears it. Data bits 8..1 are ignored.
- R4: The owner reads 0 and the other side reads 1. A free semaphore reads 1 on both sides. The two sides never own the same semaphore at the same time.
- R5: A request on a free semaphore makes the requester the owner. The next read shows this.
- R6: A request made while the other side owns the semaphore is kept, and the requester's flag stays 1. When the owner writes 1, ownership passes directly to the waiting side.
- R7: If both sides request a free semaphore on the same clock edge, the left port is granted.
- R8: A read (select and output enable high, write strobe low) captures the flag on its first cycle. It drives that flag on all nine data bits, and holds the value until select or output enable drops, even if ownership changes in the meantime.
- R9: A waiting side that writes 1 withdraws its request. When the owner later releases, the semaphore becomes free.
- R10: When a port is not reading, its read data is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel | input | 1 | Left semaphore select |
| l_wr | input | 1 | Left write strobe |
| l_oe | input | 1 | Left output enable |
| l_addr | input | ADDR_W | Left address, low 3 bits index |
| l_wdata | input | DATA_W | Left write data, bit 0 used |
| l_rdata | output | DATA_W | Left read data |
| r_sel | input | 1 | Right semaphore select |
| r_wr | input | 1 | Right write strobe |
| r_oe | input | 1 | Right output enable |
| r_addr | input | ADDR_W | Right address, low 3 bits index |
| r_wdata | input | DATA_W | Right write data, bit 0 used |
| r_rdata | output | DATA_W | Right read data |

## Verification
The bench runs a request, contend, release and handover sequence on one index and checks the flags of both sides after every step. This catches a design that drops a waiting request, since the token would then stay free after a release. It also catches a design that keeps a withdrawn request, since the token would then pass to a side that no longer wants it. A same-edge request by both sides must end with the left port granted. A design without a fixed winner would grant both sides or neither. The read-hold test changes ownership in the middle of a read. A design that reads the flag live instead of capturing it would show the new value early. Writes that set the high data and address bits show whether a design decodes too many bits.

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic              l_wr,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic              r_wr,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int IDX_W = $clog2(NUM_SEM);

  logic [IDX_W-1:0]   l_idx, r_idx;
  logic               l_wen, r_wen, l_ren, r_ren;
  logic [NUM_SEM-1:0] req_l_n, req_r_n, req_l_nx, req_r_nx;
  logic [NUM_SEM-1:0] own_l, own_r, own_l_nx, own_r_nx;
  logic               l_rd_q, r_rd_q, l_hold, r_hold;
  logic               unused_bits;

  assign l_idx = l_addr[IDX_W-1:0];
  assign r_idx = r_addr[IDX_W-1:0];
  assign l_wen = l_sel & l_wr;
  assign r_wen = r_sel & r_wr;
  assign l_ren = l_sel & l_oe & ~l_wr;
  assign r_ren = r_sel & r_oe & ~r_wr;
  assign unused_bits = ^{l_addr[ADDR_W-1:IDX_W], r_addr[ADDR_W-1:IDX_W],
                         l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};

  // request latches and ownership, left wins a same-edge tie
  always_comb begin
    req_l_nx = req_l_n;
    req_r_nx = req_r_n;
    if (l_wen) req_l_nx[l_idx] = l_wdata[0];
    if (r_wen) req_r_nx[r_idx] = r_wdata[0];
    own_l_nx = own_l;
    own_r_nx = own_r;
    for (int i = 0; i < NUM_SEM; i++) begin
      if (own_l[i]) begin
        if (req_l_nx[i]) begin
          own_l_nx[i] = 1'b0;
          own_r_nx[i] = ~req_r_nx[i];
        end
      end else if (own_r[i]) begin
        if (req_r_nx[i]) begin
          own_r_nx[i] = 1'b0;
          own_l_nx[i] = ~req_l_nx[i];
        end
      end else if (!req_l_nx[i]) begin
        own_l_nx[i] = 1'b1;
      end else if (!req_r_nx[i]) begin
        own_r_nx[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_l_n <= '1;
      req_r_n <= '1;
      own_l   <= '0;
      own_r   <= '0;
    end else begin
      req_l_n <= req_l_nx;
      req_r_n <= req_r_nx;
      own_l   <= own_l_nx;
      own_r   <= own_r_nx;
    end
  end

  // read snapshot taken on the first cycle of a read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_rd_q <= 1'b0;
      r_rd_q <= 1'b0;
      l_hold <= 1'b1;
      r_hold <= 1'b1;
    end else begin
      l_rd_q <= l_ren;
      r_rd_q <= r_ren;
      if (l_ren && !l_rd_q) l_hold <= ~own_l[l_idx];
      if (r_ren && !r_rd_q) r_hold <= ~own_r[r_idx];
    end
  end

  assign l_rdata = l_rd_q ? {DATA_W{l_hold}} : '0;
  assign r_rdata = r_rd_q ? {DATA_W{r_hold}} : '0;

  assert_single_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l & own_r) == '0);
  assert_owner_has_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((own_l & req_l_n) | (own_r & req_r_n)) == '0);
  assert_no_idle_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (~own_l & ~own_r & (~req_l_n | ~req_r_n)) == '0);
  assert_left_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rd_q && $past(l_rd_q)) |-> $stable(l_rdata));
  assert_right_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (r_rd_q && $past(r_rd_q)) |-> $stable(r_rdata));
endmodule

// File: tb/sem_bank_test.sv
`timescale 1ns/1ps
module sem_bank_test;
  localparam int AW = 17;
  localparam int DW = 9;
  localparam int NV = 19;
  // op: 0 left write, 1 right write, 2 both write | idx | ldata | rdata | expL | expR
  localparam logic [24:0] VEC [NV] = '{
    {2'd0, 3'd2, 9'h000, 9'h000, 1'b0, 1'b1},
    {2'd1, 3'd2, 9'h000, 9'h000, 1'b0, 1'b1},
    {2'd0, 3'd2, 9'h001, 9'h000, 1'b1, 1'b0},
    {2'd0, 3'd2, 9'h000, 9'h000, 1'b1, 1'b0},
    {2'd1, 3'd2, 9'h000, 9'h001, 1'b0, 1'b1},
    {2'd0, 3'd2, 9'h001, 9'h000, 1'b1, 1'b1},
    {2'd1, 3'd2, 9'h000, 9'h000, 1'b1, 1'b0},
    {2'd1, 3'd2, 9'h000, 9'h001, 1'b1, 1'b1},
    {2'd2, 3'd2, 9'h000, 9'h000, 1'b0, 1'b1},
    {2'd0, 3'd2, 9'h001, 9'h000, 1'b1, 1'b0},
    {2'd1, 3'd2, 9'h000, 9'h001, 1'b1, 1'b1},
    {2'd0, 3'd2, 9'h000, 9'h000, 1'b0, 1'b1},
    {2'd1, 3'd2, 9'h000, 9'h000, 1'b0, 1'b1},
    {2'd1, 3'd2, 9'h000, 9'h001, 1'b0, 1'b1},
    {2'd0, 3'd2, 9'h001, 9'h000, 1'b1, 1'b1},
    {2'd0, 3'd5, 9'h1FE, 9'h000, 1'b0, 1'b1},
    {2'd0, 3'd5, 9'h001, 9'h000, 1'b1, 1'b1},
    {2'd1, 3'd6, 9'h000, 9'h0FE, 1'b1, 1'b0},
    {2'd1, 3'd6, 9'h000, 9'h1FF, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic l_sel = 0, l_wr = 0, l_oe = 0, r_sel = 0, r_wr = 0, r_oe = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  int total = 0, bad = 0, cycles = 0;

  sem_bank uut (.clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<=20000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_step(input logic [1:0] op, input logic [2:0] idx,
                         input logic [DW-1:0] ld, input logic [DW-1:0] rd, input int salt);
    @(negedge clk);
    if (op != 2'd1) begin l_sel = 1; l_wr = 1; l_addr = {14'(salt * 613), idx}; l_wdata = ld; end
    if (op != 2'd0) begin r_sel = 1; r_wr = 1; r_addr = {14'(salt * 977 + 5), idx}; r_wdata = rd; end
    @(posedge clk);
    @(negedge clk);
    l_sel = 0; l_wr = 0; r_sel = 0; r_wr = 0;
  endtask

  task automatic rd_both(input logic [2:0] idx, output logic [DW-1:0] lv, output logic [DW-1:0] rv);
    @(negedge clk);
    l_sel = 1; l_oe = 1; l_addr = {14'h2AAA, idx};
    r_sel = 1; r_oe = 1; r_addr = {14'h1555, idx};
    @(posedge clk);
    @(negedge clk);
    lv = l_rdata; rv = r_rdata;
    l_sel = 0; l_oe = 0; r_sel = 0; r_oe = 0;
  endtask

  initial begin
    logic [DW-1:0] lv, rv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R10 idle left", l_rdata, '0);
    chk("R10 idle right", r_rdata, '0);
    for (int i = 0; i < 8; i++) begin
      rd_both(3'(i), lv, rv);
      chk("R1 reset left", lv, 9'h1FF);
      chk("R1 reset right", rv, 9'h1FF);
    end

    // R2 R3 R4 R5 R6 R7 R9 sequence
    for (int s = 0; s < NV; s++) begin
      wr_step(VEC[s][24:23], VEC[s][22:20], VEC[s][19:11], VEC[s][10:2], s);
      rd_both(VEC[s][22:20], lv, rv);
      chk($sformatf("R4/R6 step %0d left", s), lv, {DW{VEC[s][1]}});
      chk($sformatf("R4/R6 step %0d right", s), rv, {DW{VEC[s][0]}});
    end
    for (int i = 0; i < 8; i++) begin
      rd_both(3'(i), lv, rv);
      chk("R2 all free left", lv, 9'h1FF);
      chk("R2 all free right", rv, 9'h1FF);
    end

    // R2: a different index stays untouched while one is owned
    wr_step(2'd1, 3'd7, 9'h000, 9'h000, 3);
    rd_both(3'd0, lv, rv);
    chk("R2 neighbour left", lv, 9'h1FF);
    chk("R2 neighbour right", rv, 9'h1FF);
    wr_step(2'd1, 3'd7, 9'h000, 9'h001, 4);

    // R8 read hold across an ownership change on index 3
    wr_step(2'd1, 3'd3, 9'h000, 9'h000, 7);
    wr_step(2'd0, 3'd3, 9'h000, 9'h000, 8);
    @(negedge clk);
    l_sel = 1; l_oe = 1; l_addr = {14'h0F0F, 3'd3};
    @(posedge clk);
    @(negedge clk);
    chk("R8 capture", l_rdata, 9'h1FF);
    r_sel = 1; r_wr = 1; r_addr = {14'h0001, 3'd3}; r_wdata = 9'h001;
    @(posedge clk);
    @(negedge clk);
    r_sel = 0; r_wr = 0;
    chk("R8 held after handover", l_rdata, 9'h1FF);
    @(posedge clk);
    @(negedge clk);
    chk("R8 still held", l_rdata, 9'h1FF);
    l_oe = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 after read", l_rdata, '0);
    l_oe = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R8 fresh after toggle", l_rdata, 9'h000);
    l_sel = 0; l_oe = 0;
    wr_step(2'd0, 3'd3, 9'h001, 9'h000, 9);
    rd_both(3'd3, lv, rv);
    chk("R9 released left", lv, 9'h1FF);
    chk("R9 released right", rv, 9'h1FF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule